// File: doc/BRIEF.md
# Alternate Station Address Loader

This block runs once after every reset. It looks in nonvolatile memory for an alternate station address and, when it finds a usable one, puts that address into receive-address slot 0 in place of the factory address. It reads 16-bit words through a request/acknowledge port, one request at a time. It first reads a compatibility word and then a pointer word. A pointer of all ones or all zeros means that no alternate address is stored. Any other pointer gives the first of three consecutive words that hold the six address bytes. For the second LAN function, a fixed offset is added to the pointer before those three words are fetched.

The block drives the slot contents directly. The factory address passes through to the slot until a checked alternate address is committed. An alternate address that carries the group (multicast) bit is discarded. A read error stops the sequence and raises the error output. The block pulses done once when it finishes, whatever the outcome.

Throughout, a 48-bit station address carries byte k (k = 0 is the first byte on the wire) in bits [8k+7:8k].

Top module: `alt_addr_loader`

## Requirements
- R1: While reset is asserted, nvm_req and done are 0 and the slot shows the factory address. The slot changes only in the cycle done is 1, or when fact_addr changes.
- R2: The first request reads word address COMPAT_WADDR (default 0x0003). The second request reads PTR_WADDR (default 0x0037).
- R3: nvm_req stays high with a stable nvm_addr until the cycle nvm_ack is seen. It is then low for at least one cycle before the next request.
- R4: An acknowledge that has nvm_err set ends the sequence. done pulses with error = 1, no further request is issued, and the slot keeps the factory address.
- R5: A pointer word of 0xFFFF or 0x0000 ends the sequence with error = 0 and no further reads. The slot keeps the factory address.
- R6: When func_sel is 1, FUNC1_OFS (default 3) is added, modulo 2^16, to the pointer to form the base address. When func_sel is 0, the base address equals the pointer.
- R7: The address words are read from base, base+1 and base+2, in that order. Word i carries address byte 2i in bits [7:0] and byte 2i+1 in bits [15:8].
- R8: If bit 0 of address byte 0 is 1, the alternate address is discarded. The sequence ends with error = 0 and the slot keeps the factory address.
- R9: A committed alternate address appears as slot_lo = {byte3,byte2,byte1,byte0} and slot_hi = {byte5,byte4}.
- R10: slot_valid is 1 exactly when the address shown in the slot is nonzero.
- R11: done is a single-cycle pulse that occurs once per reset. error holds its value afterwards, and no request is made after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the sequence starts when it is released |
| fact_addr | input | 48 | Factory station address, byte k in bits [8k+7:8k] |
| func_sel | input | 1 | 1 selects the second LAN function (pointer offset applied) |
| nvm_req | output | 1 | Word read request, held until acknowledged |
| nvm_addr | output | 16 | Word address of the current request |
| nvm_ack | input | 1 | Read acknowledge, one cycle, valid only while nvm_req is high |
| nvm_rdata | input | 16 | Read data, valid with nvm_ack |
| nvm_err | input | 1 | Read failure flag, valid with nvm_ack |
| slot_lo | output | 32 | Slot 0 low word (bytes 3..0) |
| slot_hi | output | 16 | Slot 0 high part (bytes 5..4) |
| slot_valid | output | 1 | Slot 0 address-valid bit |
| done | output | 1 | One-cycle pulse at the end of the sequence |
| error | output | 1 | Set when a read failed; held until reset |

## Verification
The bound checker watches the properties that hold on every cycle. These are the request/acknowledge discipline (the held request, the stable address and the gap after an acknowledge), the single done pulse, the quiet port after done, the error rising only with done, and the slot holding steady outside the done cycle. Other behaviours can only be shown by the bench's scenarios against its NVM model and scoreboard. These include the order and addresses of the reads, the pointer sentinels, the function offset, the byte placement within words, the group-bit rejection, the little-endian packing and the valid bit for an all-zero address.

// File: rtl/alt_addr_loader.sv
module alt_addr_loader #(
  parameter int          AW           = 16,
  parameter logic [15:0] COMPAT_WADDR = 16'h0003,
  parameter logic [15:0] PTR_WADDR    = 16'h0037,
  parameter logic [15:0] FUNC1_OFS    = 16'h0003
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [47:0]   fact_addr,
  input  logic          func_sel,
  output logic          nvm_req,
  output logic [AW-1:0] nvm_addr,
  input  logic          nvm_ack,
  input  logic [15:0]   nvm_rdata,
  input  logic          nvm_err,
  output logic [31:0]   slot_lo,
  output logic [15:0]   slot_hi,
  output logic          slot_valid,
  output logic          done,
  output logic          error
);
  typedef enum logic [2:0] {ST_COMPAT, ST_PTR, ST_W0, ST_W1, ST_W2, ST_END} st_t;

  localparam logic [AW-1:0] NONE_LO = '0;
  localparam logic [AW-1:0] NONE_HI = '1;

  st_t           st;
  logic          req_q, done_q, err_q, use_alt;
  logic [AW-1:0] base;
  logic [47:0]   alt;
  logic [47:0]   shown;

  assign shown      = use_alt ? alt : fact_addr;
  assign slot_lo    = shown[31:0];
  assign slot_hi    = shown[47:32];
  assign slot_valid = |shown;
  assign nvm_req    = req_q;
  assign done       = done_q;
  assign error      = err_q;

  always_comb begin
    case (st)
      ST_COMPAT: nvm_addr = COMPAT_WADDR[AW-1:0];
      ST_PTR:    nvm_addr = PTR_WADDR[AW-1:0];
      ST_W1:     nvm_addr = base + AW'(1);
      ST_W2:     nvm_addr = base + AW'(2);
      default:   nvm_addr = base;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_COMPAT;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      use_alt <= 1'b0;
      base    <= '0;
      alt     <= '0;
    end else begin
      done_q <= 1'b0;
      if (st != ST_END) begin
        if (!req_q) begin
          req_q <= 1'b1;
        end else if (nvm_ack) begin
          req_q <= 1'b0;
          if (nvm_err) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            st     <= ST_END;
          end else begin
            case (st)
              ST_COMPAT: st <= ST_PTR;
              ST_PTR: begin
                if (nvm_rdata[AW-1:0] == NONE_LO || nvm_rdata[AW-1:0] == NONE_HI) begin
                  done_q <= 1'b1;
                  st     <= ST_END;
                end else begin
                  base <= nvm_rdata[AW-1:0] + (func_sel ? FUNC1_OFS[AW-1:0] : NONE_LO);
                  st   <= ST_W0;
                end
              end
              ST_W0: begin
                alt[15:0] <= nvm_rdata;
                st        <= ST_W1;
              end
              ST_W1: begin
                alt[31:16] <= nvm_rdata;
                st         <= ST_W2;
              end
              ST_W2: begin
                alt[47:32] <= nvm_rdata;
                use_alt    <= ~alt[0];
                done_q     <= 1'b1;
                st         <= ST_END;
              end
              default: st <= ST_END;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/alt_addr_loader_chk.sv
module alt_addr_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [47:0] fact_addr,
  input logic        nvm_req,
  input logic [15:0] nvm_addr,
  input logic        nvm_ack,
  input logic [31:0] slot_lo,
  input logic [15:0] slot_hi,
  input logic        done,
  input logic        error
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_req && !nvm_ack |=> nvm_req && $stable(nvm_addr));

  p_req_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_req && nvm_ack |=> !nvm_req);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_quiet_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !nvm_req);

  p_err_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done);

  p_slot_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !done && $stable(fact_addr) |-> $stable({slot_hi, slot_lo}));
endmodule

bind alt_addr_loader alt_addr_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fact_addr(fact_addr), .nvm_req(nvm_req),
  .nvm_addr(nvm_addr), .nvm_ack(nvm_ack), .slot_lo(slot_lo), .slot_hi(slot_hi),
  .done(done), .error(error)
);

// File: tb/test_alt_addr_loader.sv
module test_alt_addr_loader;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] COMPAT = 16'h0003;
  localparam logic [15:0] PTR    = 16'h0037;
  localparam logic [15:0] OFS    = 16'h0003;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [47:0] fact_addr = '0;
  logic        func_sel = 0;
  logic        nvm_req;
  logic [15:0] nvm_addr;
  logic        nvm_ack = 0;
  logic [15:0] nvm_rdata = '0;
  logic        nvm_err = 0;
  logic [31:0] slot_lo;
  logic [15:0] slot_hi;
  logic        slot_valid;
  logic        done;
  logic        error;

  always #(CLK_PERIOD/2) clk = ~clk;

  alt_addr_loader i_alt_addr_loader (
    .clk(clk), .rst_n(rst_n), .fact_addr(fact_addr), .func_sel(func_sel),
    .nvm_req(nvm_req), .nvm_addr(nvm_addr), .nvm_ack(nvm_ack),
    .nvm_rdata(nvm_rdata), .nvm_err(nvm_err), .slot_lo(slot_lo),
    .slot_hi(slot_hi), .slot_valid(slot_valid), .done(done), .error(error)
  );

  typedef struct {
    logic [31:0] lo;
    logic [15:0] hi;
    logic        v;
    logic        e;
  } res_t;

  int n_chk = 0;
  int n_bad = 0;
  res_t        exp_q[$];
  logic [15:0] addr_q[$];
  logic [15:0] mem [logic [15:0]];
  int err_at = -1;
  int lat = 0;
  bit prev_done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // NVM model: checks each request address against the expected order
  initial begin
    forever begin
      @(negedge clk);
      nvm_ack = 0;
      nvm_err = 0;
      if (rst_n && nvm_req) begin
        logic [15:0] a;
        a = nvm_addr;
        if (addr_q.size() == 0)
          chk(0, "R2", "unexpected read", {48'h0, a}, 64'h0);
        else begin
          logic [15:0] ea;
          ea = addr_q.pop_front();
          chk(a == ea, "R2/R6/R7", "read address", {48'h0, a}, {48'h0, ea});
        end
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          chk(nvm_req && nvm_addr == a, "R3", "request held",
              {47'h0, nvm_req, nvm_addr}, {47'h0, 1'b1, a});
        end
        nvm_ack   = 1;
        nvm_rdata = mem.exists(a) ? mem[a] : 16'hFFFF;
        nvm_err   = (int'(a) == err_at);
      end
    end
  end

  // Monitor: pops the scoreboard when done pulses
  initial begin
    forever begin
      @(negedge clk);
      if (prev_done)
        chk(!done, "R11", "done single pulse", {63'h0, done}, 64'h0);
      prev_done = rst_n && done;
      if (rst_n && done) begin
        if (exp_q.size() == 0)
          chk(0, "R11", "unexpected done", 64'h1, 64'h0);
        else begin
          res_t r;
          r = exp_q.pop_front();
          chk(slot_lo == r.lo, "R9", "slot_lo", {32'h0, slot_lo}, {32'h0, r.lo});
          chk(slot_hi == r.hi, "R9", "slot_hi", {48'h0, slot_hi}, {48'h0, r.hi});
          chk(slot_valid == r.v, "R10", "slot_valid", {63'h0, slot_valid}, {63'h0, r.v});
          chk(error == r.e, "R4", "error", {63'h0, error}, {63'h0, r.e});
        end
      end
    end
  end

  // Driver: computes the expected outcome and pushes it
  task automatic scenario(input logic [47:0] fa, input logic fs, input logic [15:0] ptr,
                          input logic [47:0] alt, input int ea, input int l);
    logic [15:0] base;
    logic [47:0] pick;
    bit bad;
    res_t r;
    @(negedge clk);
    rst_n = 0;
    fact_addr = fa;
    func_sel = fs;
    err_at = ea;
    lat = l;
    mem.delete();
    mem[COMPAT] = 16'h5A5A;
    mem[PTR] = ptr;
    base = ptr + (fs ? OFS : 16'h0);
    bad = 0;
    pick = fa;
    addr_q.push_back(COMPAT);
    if (ea == int'(COMPAT)) bad = 1;
    if (!bad) begin
      addr_q.push_back(PTR);
      if (ea == int'(PTR)) bad = 1;
    end
    if (!bad && ptr != 16'h0000 && ptr != 16'hFFFF) begin
      for (int i = 0; i < 3; i++) begin
        if (!bad) begin
          mem[base + 16'(i)] = alt[16*i +: 16];
          addr_q.push_back(base + 16'(i));
          if (ea == int'(base + 16'(i))) bad = 1;
        end
      end
      if (!bad && !alt[0]) pick = alt;
    end
    r.lo = pick[31:0];
    r.hi = pick[47:32];
    r.v  = (pick != 48'h0);
    r.e  = bad;
    exp_q.push_back(r);
    repeat (2) @(negedge clk);
    chk(!nvm_req && !done, "R1", "reset outputs", {62'h0, nvm_req, done}, 64'h0);
    chk({slot_hi, slot_lo} == fa, "R1", "reset slot", {16'h0, slot_hi, slot_lo}, {16'h0, fa});
    rst_n = 1;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(addr_q.size() == 0, "R5", "reads left", 64'(addr_q.size()), 64'h0);
    addr_q.delete();
    chk(error == bad, "R11", "error held", {63'h0, error}, {63'h0, bad});
    chk(!nvm_req, "R11", "no request after done", {63'h0, nvm_req}, 64'h0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog: actual timeout expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R5: sentinel pointers
    scenario(48'h665544332211, 0, 16'hFFFF, 48'h0, -1, 0);
    scenario(48'h665544332210, 0, 16'h0000, 48'h0, -1, 2);
    // R7 R9: valid alternate on function 0
    scenario(48'h665544332210, 0, 16'h0040, 48'h554433221102, -1, 1);
    // R6: second function offset
    scenario(48'h665544332210, 1, 16'h0040, 48'hA0B0C0D0E0F2, -1, 3);
    // R6: offset wraps at 16 bits
    scenario(48'h0000000000AA, 1, 16'hFFFE, 48'h121314151618, -1, 0);
    // R8: group bit set
    scenario(48'h665544332210, 0, 16'h0100, 48'h554433221103, -1, 0);
    // R4: errors at each stage
    scenario(48'h0A0B0C0D0E00, 0, 16'h0040, 48'h554433221102, int'(COMPAT), 1);
    scenario(48'h0A0B0C0D0E00, 0, 16'h0040, 48'h554433221102, int'(PTR), 0);
    scenario(48'h0A0B0C0D0E00, 0, 16'h0040, 48'h554433221102, 16'h0041, 2);
    scenario(48'h0A0B0C0D0E00, 1, 16'h0040, 48'h554433221102, 16'h0045, 1);
    // R10: zero factory address, and zero alternate address
    scenario(48'h0, 0, 16'hFFFF, 48'h0, -1, 0);
    scenario(48'h665544332210, 0, 16'h0200, 48'h0, -1, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule